// File: doc/BRIEF.md
# Synchronous PSRAM Burst Read Controller

This block sits on the host side of a synchronous pseudo-static RAM and performs one burst read for each accepted request. A request carries a start address and a burst-length code. The controller samples its configuration inputs when it accepts the request: the latency count, fixed or variable latency, and whether the low address bits share the data pins. It then drives a one-cycle address phase, waits out the programmed latency, and captures one data word per clock from the memory's data lines. In variable-latency mode it holds off capture while the memory reports not-ready.

Captured words leave on a valid/data stream, and the final word of the burst is flagged. The memory is clocked by the controller's own clock. Every control pin is a decode of registered state, so none of them depends combinationally on an input.

Top module: `psram_burst_rd`

## Requirements
- R1: After a synchronous reset, and whenever no burst is in progress, `req_ready` is 1, `rd_valid` is 0, `mem_ce_n`, `mem_adv_n`, `mem_oe_n`, `mem_ub_n`, `mem_lb_n` and `mem_we_n` are 1, `mem_cre` is 0 and `mem_dq_oe` is 0.
- R2: A request is taken on a rising edge where `req_valid` and `req_ready` are both 1. The cycle that follows is the single address cycle. In it `mem_ce_n`, `mem_adv_n`, `mem_ub_n` and `mem_lb_n` are 0, `mem_oe_n` and `mem_we_n` are 1, `mem_cre` is 0 and `mem_addr` equals the requested address. Its closing edge latches the address in the memory.
- R3: With a latency count L (a value of 0 counts as 1), the first word is sampled from `mem_dq_in` on the L-th rising edge after the edge that closes the address cycle. It appears on `rd_data`, with `rd_valid` at 1, during the cycle after that edge.
- R4: In fixed-latency mode (`cfg_var_lat` = 0), each later word is sampled on the very next rising edge, whatever the level of `mem_wait_n`.
- R5: In variable-latency mode (`cfg_var_lat` = 1), `mem_wait_n` is active-low not-ready. On any edge where a word is due and `mem_wait_n` is 0, no word is sampled and `rd_valid` is 0 in the following cycle. Sampling resumes on the next edge where `mem_wait_n` is 1.
- R6: `req_len` codes 0, 1 and 2 select bursts of 4, 8 and 16 words. The final word carries `rd_last` = 1. In that same cycle `mem_ce_n` is back at 1 and `req_ready` is 1.
- R7: `req_len` code 3 selects a continuous burst. It ends with the word sampled on an edge where `burst_stop` is 1, and that word carries `rd_last`.
- R8: With `cfg_muxed` = 1, the address cycle drives `mem_dq_out` with the low data-width bits of the address and sets `mem_dq_oe` to 1. With `cfg_muxed` = 0, `mem_dq_oe` stays 0. In every cycle after the address cycle, `mem_dq_oe` is 0 and `mem_adv_n` is 1.
- R9: From the cycle after the address cycle until the burst ends, `mem_ce_n`, `mem_oe_n`, `mem_ub_n` and `mem_lb_n` are 0, and `mem_adv_n` and `mem_we_n` are 1.
- R10: The latency count, the latency mode, the shared-pin mode and the length code are all taken as they stand at acceptance. Changing them during a burst has no effect on that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller and memory clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Burst request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_addr | input | ADDR_W | Burst start address |
| req_len | input | 2 | Length code: 0=4, 1=8, 2=16, 3=continuous |
| cfg_latency | input | LAT_W | Latency count in clocks |
| cfg_var_lat | input | 1 | 1 = variable latency, honour wait pin |
| cfg_muxed | input | 1 | 1 = low address bits share data pins |
| burst_stop | input | 1 | Ends a continuous burst at the next sampled word |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_adv_n | output | 1 | Address valid, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, held inactive |
| mem_cre | output | 1 | Configuration-register select, held low |
| mem_ub_n | output | 1 | Upper byte enable, active low |
| mem_lb_n | output | 1 | Lower byte enable, active low |
| mem_wait_n | input | 1 | Memory not-ready flag, active low |
| mem_addr | output | ADDR_W | Address lines |
| mem_dq_out | output | DATA_W | Data pins driven value (address in shared mode) |
| mem_dq_oe | output | 1 | Drive enable for the data pins |
| mem_dq_in | input | DATA_W | Data pins received value |
| rd_valid | output | 1 | Returned word valid |
| rd_data | output | DATA_W | Returned word |
| rd_last | output | 1 | Returned word is the final one of the burst |

## Verification
The assertions hold the pin rules on every cycle. The address cycle lasts one clock and happens with output enable off. In data phases the address strobe is released and the bus is not driven. A returned word always follows a cycle with output enable on, a not-ready flag in variable mode blocks the next word, and the last word lines up with chip enable going high. Only the bench's scenarios can show the timing and the values. It checks the exact edge of the first word for each latency, including zero, and the word counts for each length code. It also checks that the wait pin is ignored in fixed mode, that a continuous burst ends on the stop input, and that configuration changes made mid-burst are ignored. It does this by comparing a behavioural model against the ports on every clock.

// File: rtl/psram_rd_pkg.sv
package psram_rd_pkg;

    localparam int LAT_W  = 4;
    localparam int WCNT_W = 5;

    typedef enum logic [1:0] {
        BL_4    = 2'd0,
        BL_8    = 2'd1,
        BL_16   = 2'd2,
        BL_CONT = 2'd3
    } burst_len_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2
    } rd_state_e;

    typedef struct packed {
        logic [LAT_W-1:0] latency;
        logic             var_lat;
        logic             muxed;
        burst_len_e       len;
    } burst_cfg_t;

    typedef struct packed {
        logic ce_n;
        logic adv_n;
        logic oe_n;
        logic we_n;
        logic cre;
        logic ub_n;
        logic lb_n;
        logic dq_oe;
    } mem_ctl_t;

    // number of words in a fixed-length burst (continuous returns 0)
    function automatic logic [WCNT_W-1:0] words_for(burst_len_e l);
        case (l)
            BL_4:    return WCNT_W'(4);
            BL_8:    return WCNT_W'(8);
            BL_16:   return WCNT_W'(16);
            default: return '0;
        endcase
    endfunction

    // counter preload: a zero latency behaves like a latency of one
    function automatic logic [LAT_W-1:0] latency_load(logic [LAT_W-1:0] l);
        return (l == '0) ? '0 : l - LAT_W'(1);
    endfunction

endpackage

// File: rtl/psram_rd_seq.sv
module psram_rd_seq
    import psram_rd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_fire,
    input  burst_cfg_t cfg_in,
    input  logic       mem_wait_n,
    input  logic       stop_in,
    output rd_state_e  state_q,
    output burst_cfg_t cfg_q,
    output logic       capture,
    output logic       last_word
);

    logic [LAT_W-1:0]  lat_q;
    logic [WCNT_W-1:0] words_q;
    logic              lat_done;
    logic              fixed_end;

    assign lat_done  = (lat_q == '0);
    assign capture   = (state_q == ST_DATA) && lat_done &&
                       (!cfg_q.var_lat || mem_wait_n);
    assign fixed_end = (words_q == words_for(cfg_q.len) - WCNT_W'(1));
    assign last_word = capture && ((cfg_q.len == BL_CONT) ? stop_in : fixed_end);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cfg_q   <= '0;
            lat_q   <= '0;
            words_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_fire) begin
                        cfg_q   <= cfg_in;
                        state_q <= ST_ADDR;
                    end
                end
                ST_ADDR: begin
                    lat_q   <= latency_load(cfg_q.latency);
                    words_q <= '0;
                    state_q <= ST_DATA;
                end
                ST_DATA: begin
                    if (!lat_done)
                        lat_q <= lat_q - LAT_W'(1);
                    if (capture)
                        words_q <= words_q + WCNT_W'(1);
                    if (last_word)
                        state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/psram_rd_pins.sv
module psram_rd_pins
    import psram_rd_pkg::*;
#(
    parameter int ADDR_W = 23,
    parameter int DATA_W = 16
) (
    input  rd_state_e         state_q,
    input  logic              muxed,
    input  logic [ADDR_W-1:0] addr_q,
    output mem_ctl_t          ctl,
    output logic [DATA_W-1:0] dq_out
);

    generate
        if (ADDR_W >= DATA_W) begin : g_slice
            assign dq_out = addr_q[DATA_W-1:0];
        end else begin : g_extend
            assign dq_out = {{(DATA_W-ADDR_W){1'b0}}, addr_q};
        end
    endgenerate

    always_comb begin
        ctl      = '{ce_n: 1'b1, adv_n: 1'b1, oe_n: 1'b1, we_n: 1'b1,
                     cre: 1'b0, ub_n: 1'b1, lb_n: 1'b1, dq_oe: 1'b0};
        case (state_q)
            ST_ADDR: begin
                ctl.ce_n  = 1'b0;
                ctl.adv_n = 1'b0;
                ctl.ub_n  = 1'b0;
                ctl.lb_n  = 1'b0;
                ctl.dq_oe = muxed;
            end
            ST_DATA: begin
                ctl.ce_n = 1'b0;
                ctl.oe_n = 1'b0;
                ctl.ub_n = 1'b0;
                ctl.lb_n = 1'b0;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/psram_rd_capture.sv
module psram_rd_capture #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic              last_word,
    input  logic [DATA_W-1:0] dq_in,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_last
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_last  <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= capture;
            rd_last  <= last_word;
            if (capture)
                rd_data <= dq_in;
        end
    end

endmodule

// File: rtl/psram_burst_rd.sv
module psram_burst_rd
    import psram_rd_pkg::*;
#(
    parameter int ADDR_W = 23,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_len,
    input  logic [LAT_W-1:0]  cfg_latency,
    input  logic              cfg_var_lat,
    input  logic              cfg_muxed,
    input  logic              burst_stop,
    output logic              mem_ce_n,
    output logic              mem_adv_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_cre,
    output logic              mem_ub_n,
    output logic              mem_lb_n,
    input  logic              mem_wait_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_last
);

    rd_state_e         state_q;
    burst_cfg_t        cfg_in;
    burst_cfg_t        cfg_q;
    mem_ctl_t          ctl;
    logic [ADDR_W-1:0] addr_q;
    logic              req_fire;
    logic              capture;
    logic              last_word;

    assign req_ready = (state_q == ST_IDLE);
    assign req_fire  = req_valid && req_ready;
    assign cfg_in    = '{latency: cfg_latency, var_lat: cfg_var_lat,
                         muxed: cfg_muxed, len: burst_len_e'(req_len)};

    always_ff @(posedge clk) begin
        if (rst)
            addr_q <= '0;
        else if (req_fire)
            addr_q <= req_addr;
    end

    psram_rd_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .req_fire   (req_fire),
        .cfg_in     (cfg_in),
        .mem_wait_n (mem_wait_n),
        .stop_in    (burst_stop),
        .state_q    (state_q),
        .cfg_q      (cfg_q),
        .capture    (capture),
        .last_word  (last_word)
    );

    psram_rd_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
        .state_q (state_q),
        .muxed   (cfg_q.muxed),
        .addr_q  (addr_q),
        .ctl     (ctl),
        .dq_out  (mem_dq_out)
    );

    psram_rd_capture #(.DATA_W(DATA_W)) u_cap (
        .clk       (clk),
        .rst       (rst),
        .capture   (capture),
        .last_word (last_word),
        .dq_in     (mem_dq_in),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .rd_last   (rd_last)
    );

    assign mem_ce_n  = ctl.ce_n;
    assign mem_adv_n = ctl.adv_n;
    assign mem_oe_n  = ctl.oe_n;
    assign mem_we_n  = ctl.we_n;
    assign mem_cre   = ctl.cre;
    assign mem_ub_n  = ctl.ub_n;
    assign mem_lb_n  = ctl.lb_n;
    assign mem_dq_oe = ctl.dq_oe;
    assign mem_addr  = addr_q;

endmodule

// File: rtl/psram_rd_checker.sv
module psram_rd_checker (
    input logic clk,
    input logic rst,
    input logic req_ready,
    input logic mem_ce_n,
    input logic mem_adv_n,
    input logic mem_oe_n,
    input logic mem_we_n,
    input logic mem_cre,
    input logic mem_ub_n,
    input logic mem_lb_n,
    input logic mem_wait_n,
    input logic mem_dq_oe,
    input logic var_q,
    input logic rd_valid,
    input logic rd_last
);

    assert_idle_ce_R1: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> mem_ce_n);

    assert_addr_pins_R2: assert property (@(posedge clk) disable iff (rst)
        !mem_adv_n |-> (!mem_ce_n && mem_oe_n && mem_we_n && !mem_cre));

    assert_addr_one_cycle_R2: assert property (@(posedge clk) disable iff (rst)
        !mem_adv_n |=> mem_adv_n);

    assert_word_after_oe_R3: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(!mem_oe_n));

    assert_wait_blocks_R5: assert property (@(posedge clk) disable iff (rst)
        (!mem_oe_n && var_q && !mem_wait_n) |=> !rd_valid);

    assert_last_ends_R6: assert property (@(posedge clk) disable iff (rst)
        rd_last |-> (rd_valid && mem_ce_n));

    assert_bus_release_R8: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> !mem_adv_n);

    assert_data_pins_R9: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> (!mem_ce_n && mem_adv_n && !mem_ub_n && !mem_lb_n));

endmodule

bind psram_burst_rd psram_rd_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_ready  (req_ready),
    .mem_ce_n   (mem_ce_n),
    .mem_adv_n  (mem_adv_n),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_cre    (mem_cre),
    .mem_ub_n   (mem_ub_n),
    .mem_lb_n   (mem_lb_n),
    .mem_wait_n (mem_wait_n),
    .mem_dq_oe  (mem_dq_oe),
    .var_q      (cfg_q.var_lat),
    .rd_valid   (rd_valid),
    .rd_last    (rd_last)
);

// File: tb/tb_psram_burst_rd.sv
module tb_psram_burst_rd;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 23;
    localparam int DATA_W = 16;
    localparam int LAT_W  = 4;
    localparam int WATCHDOG = 20000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [1:0]        req_len = '0;
    logic [LAT_W-1:0]  cfg_latency = '0;
    logic              cfg_var_lat = 1'b0;
    logic              cfg_muxed = 1'b0;
    logic              burst_stop = 1'b0;
    logic              mem_ce_n, mem_adv_n, mem_oe_n, mem_we_n, mem_cre;
    logic              mem_ub_n, mem_lb_n;
    logic              mem_wait_n = 1'b1;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_dq_out;
    logic              mem_dq_oe;
    logic [DATA_W-1:0] mem_dq_in = '0;
    logic              rd_valid;
    logic [DATA_W-1:0] rd_data;
    logic              rd_last;

    always #(CLK_PERIOD/2) clk = ~clk;

    psram_burst_rd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .cfg_latency(cfg_latency),
        .cfg_var_lat(cfg_var_lat), .cfg_muxed(cfg_muxed), .burst_stop(burst_stop),
        .mem_ce_n(mem_ce_n), .mem_adv_n(mem_adv_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_cre(mem_cre), .mem_ub_n(mem_ub_n),
        .mem_lb_n(mem_lb_n), .mem_wait_n(mem_wait_n), .mem_addr(mem_addr),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_last(rd_last)
    );

    int    vectors = 0;
    int    miscompares = 0;
    int    cyc = 0;
    bit    stall_en = 1'b0;
    bit    done = 1'b0;
    string cur_tag = "R1";

    // behavioural model state
    int                m_phase = 0;        // 0 idle, 1 address, 2 data
    int                m_wait = 0;
    int                m_words = 0;
    int                m_total = 0;        // words expected, 0 = until stop
    int                m_lat = 0;
    bit                m_var = 0;
    bit                m_mux = 0;
    logic [ADDR_W-1:0] m_addr = '0;
    bit                e_valid = 0;
    bit                e_last = 0;
    logic [DATA_W-1:0] e_data = '0;
    int                seen_words = 0;

    // memory side stimulus: data changes every cycle, wait optionally pulses
    always @(negedge clk) begin
        cyc <= cyc + 1;
        mem_dq_in  <= DATA_W'((cyc * 40503) ^ 23130);
        mem_wait_n <= stall_en ? ((cyc % 5) != 2 && (cyc % 7) != 4) : 1'b1;
    end

    always @(posedge clk) begin
        if (rst) begin
            m_phase = 0; e_valid = 0; e_last = 0;
        end else begin
            e_valid = 0;
            e_last  = 0;
            case (m_phase)
                0: if (req_valid) begin
                    m_addr  = req_addr;
                    m_lat   = (cfg_latency == 0) ? 1 : int'(cfg_latency);
                    m_var   = cfg_var_lat;
                    m_mux   = cfg_muxed;
                    m_total = (req_len == 2'd3) ? 0 : (4 << req_len);
                    m_phase = 1;
                end
                1: begin
                    m_wait  = m_lat - 1;
                    m_words = 0;
                    m_phase = 2;
                end
                default: begin
                    if (m_wait > 0) m_wait = m_wait - 1;
                    else if (!(m_var && !mem_wait_n)) begin
                        e_valid = 1;
                        e_data  = mem_dq_in;
                        m_words = m_words + 1;
                        e_last  = (m_total == 0) ? burst_stop : (m_words == m_total);
                        if (e_last) m_phase = 0;
                    end
                end
            endcase
        end
    end

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0h expected %0h at cycle %0d",
                     tag, what, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            string ptag;
            bit    e_ce, e_adv, e_oe;
            ptag  = (m_phase == 0) ? "R1" : (m_phase == 1) ? "R2" : "R9";
            e_ce  = (m_phase == 0);
            e_adv = (m_phase != 1);
            e_oe  = (m_phase != 2);
            vectors++;
            chk(ptag, "req_ready", req_ready, m_phase == 0);
            chk(ptag, "mem_ce_n", mem_ce_n, e_ce);
            chk(ptag, "mem_adv_n", mem_adv_n, e_adv);
            chk(ptag, "mem_oe_n", mem_oe_n, e_oe);
            chk(ptag, "mem_ub_n", mem_ub_n, e_ce);
            chk(ptag, "mem_lb_n", mem_lb_n, e_ce);
            chk(ptag, "mem_we_n", mem_we_n, 1);
            chk(ptag, "mem_cre", mem_cre, 0);
            chk("R8", "mem_dq_oe", mem_dq_oe, (m_phase == 1) && m_mux);
            if (m_phase == 1) begin
                chk("R2", "mem_addr", 32'(mem_addr), 32'(m_addr));
                if (m_mux) chk("R8", "mem_dq_out", 32'(mem_dq_out), 32'(m_addr[DATA_W-1:0]));
            end
            chk(cur_tag, "rd_valid", rd_valid, e_valid);
            chk(cur_tag, "rd_last", rd_last, e_last);
            if (e_valid) chk(cur_tag, "rd_data", 32'(rd_data), 32'(e_data));
            if (rd_valid) seen_words++;
        end
    end

    task automatic burst(input string tag, input logic [ADDR_W-1:0] a,
                         input logic [1:0] len, input int lat, input bit var_l,
                         input bit mux, input bit stalls, input int stop_after,
                         input bit perturb, input int exp_words);
        cur_tag    = tag;
        stall_en   = stalls;
        seen_words = 0;
        @(negedge clk);
        req_valid   = 1'b1;
        req_addr    = a;
        req_len     = len;
        cfg_latency = LAT_W'(lat);
        cfg_var_lat = var_l;
        cfg_muxed   = mux;
        @(negedge clk);
        req_valid = 1'b0;
        if (perturb) begin
            // R10: change every setting while the burst runs
            req_len = 2'd3; cfg_latency = 4'd15; cfg_var_lat = ~var_l; cfg_muxed = ~mux;
        end
        for (int i = 0; i < 400 && m_phase != 0; i++) begin
            if (stop_after > 0 && i == stop_after) burst_stop = 1'b1;
            @(negedge clk);
        end
        burst_stop = 1'b0;
        @(negedge clk);
        if (exp_words > 0) begin
            vectors++;
            chk(tag, "word count", 32'(seen_words), 32'(exp_words));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state is compared by the per-cycle check above
        burst("R4", 23'h012345, 2'd0, 3, 0, 0, 1, 0, 0, 4);   // fixed, wait ignored
        burst("R3", 23'h000010, 2'd0, 0, 0, 0, 0, 0, 0, 4);   // zero latency
        burst("R3", 23'h0000A0, 2'd0, 15, 0, 0, 0, 0, 0, 4);  // longest latency
        burst("R5", 23'h7F0001, 2'd1, 4, 1, 0, 1, 0, 0, 8);   // variable with stalls
        burst("R6", 23'h055AA5, 2'd2, 2, 0, 1, 0, 0, 0, 16);  // shared pins, 16 words
        burst("R8", 23'h3C3C3C, 2'd1, 1, 1, 1, 1, 0, 0, 8);   // shared pins, stalls
        burst("R7", 23'h111111, 2'd3, 3, 1, 0, 1, 20, 0, 0);  // continuous until stop
        burst("R7", 23'h222222, 2'd3, 2, 0, 0, 0, 9, 0, 0);   // continuous fixed mode
        burst("R10", 23'h400400, 2'd0, 5, 0, 0, 1, 0, 1, 4);  // settings change mid-burst
        // R6: back-to-back requests, valid held high across the boundary
        cur_tag = "R6";
        @(negedge clk);
        req_valid = 1'b1; req_addr = 23'h000777; req_len = 2'd0;
        cfg_latency = 4'd2; cfg_var_lat = 1'b0; cfg_muxed = 1'b0;
        repeat (30) @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 100 && m_phase != 0; i++) @(negedge clk);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    always @(posedge clk) begin
        if (cyc > WATCHDOG && !done) begin
            done = 1'b1;
            miscompares++;
            $display("FAIL watchdog: actual cycle %0d expected below %0d", cyc, WATCHDOG);
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule